// File: doc/BRIEF.md
# Parallel-Prefix Adder/Subtractor

This block adds or subtracts two unsigned words of a parameterised power-of-two width. Its carries come from a log-depth prefix network rather than a ripple chain. Each bit first forms a generate term and a propagate term. The incoming carry is merged into the lowest bit's generate term. A tree of combining cells then produces, for every bit, the generate of the whole span down to bit zero. That span generate is the carry into the next bit. Each sum bit is that bit's propagate term XORed with the carry into it. The generate of the full word is the carry-out.

Subtraction works by adding the two's complement. The second operand is inverted bit by bit through XOR with the subtract control, and the carry into bit zero is forced high. In this mode the carry-out is 1 exactly when no borrow occurs, that is when the first operand is not smaller than the second. A parameter places an optional register on the result. With the register, the sum and carry appear one clock after the operands and are cleared by a synchronous reset. Without it, the block is purely combinational.

Top module: `pfx_addsub`

## Requirements
- R1: With the subtract control low, the sum output equals the low WIDTH bits of A + B + carry-in, and the carry output equals bit WIDTH of that total.
- R2: With the subtract control high, the sum output equals (A - B) modulo 2^WIDTH, and the carry-in input has no effect on either output.
- R3: With the subtract control high, the carry output is 1 when A >= B (no borrow) and 0 when A < B.
- R4: A carry-in of 1 propagates through every bit position. For example, 0xAAAA + 0x5555 + 1 gives sum 0x0000 with carry 1, and 0xFFFF + 0x0000 + 1 gives the same.
- R5: With OUT_REG=1, the outputs show the result of the operands present before a rising clock edge and hold it until the next edge. With OUT_REG=0, the outputs follow the operands within the same cycle.
- R6: With OUT_REG=1, a high reset sampled at a rising edge sets the sum to 0 and the carry to 0, regardless of the operands. The outputs stay at 0 for as long as reset remains high.
- R7: The same behaviour holds for any power-of-two WIDTH of at least 2, with the prefix network depth equal to log2(WIDTH).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset of the result register |
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand (subtrahend when subtracting) |
| sub_i | input | 1 | 1 = subtract, 0 = add |
| cin_i | input | 1 | Carry-in, used only when adding |
| sum_o | output | WIDTH | Sum or difference |
| cout_o | output | 1 | Carry-out; when subtracting, 1 means no borrow |

## Verification
The bench builds two instances. The first uses WIDTH=16 with OUT_REG=1, which brings the register's one-cycle latency, its hold between edges and its synchronous clear within reach, together with a four-level tree. The second uses WIDTH=8 with OUT_REG=0, which exposes the combinational path, checks that the width parameter reshapes the network to three levels, and makes the full-word wrap and borrow corners cheap to hit. Both instances also take random operands in each mode, checked against the arithmetic stated in the requirements.

// File: rtl/pfx_pkg.sv
package pfx_pkg;

  // Number of combining levels a prefix network needs for w bits.
  function automatic int unsigned prefix_levels(input int unsigned w);
    return $clog2(w);
  endfunction

  // True when w is a power of two no smaller than 2.
  function automatic bit width_ok(input int unsigned w);
    return (w >= 2) && ((w & (w - 1)) == 0);
  endfunction

endpackage

// File: rtl/pfx_pg.sv
// Bitwise generate/propagate stage with operand inversion for subtraction.
// The effective carry into bit 0 is folded into that bit's generate term.
module pfx_pg #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] gen_o,
  output logic [WIDTH-1:0] prop_o,
  output logic             c0_o
);
  logic [WIDTH-1:0] b_eff;
  logic [WIDTH-1:0] gen_raw;

  assign b_eff   = b_i ^ {WIDTH{sub_i}};
  assign c0_o    = sub_i | cin_i;
  assign prop_o  = a_i ^ b_eff;
  assign gen_raw = a_i & b_eff;
  assign gen_o   = {gen_raw[WIDTH-1:1], gen_raw[0] | (prop_o[0] & c0_o)};
endmodule

// File: rtl/pfx_black.sv
// Combining cell that yields both group generate and group propagate.
module pfx_black (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  input  logic p_lo,
  output logic g_o,
  output logic p_o
);
  assign g_o = g_hi | (p_hi & g_lo);
  assign p_o = p_hi & p_lo;
endmodule

// File: rtl/pfx_gray.sv
// Combining cell for spans that reach bit 0: group generate only.
module pfx_gray (
  input  logic g_hi,
  input  logic p_hi,
  input  logic g_lo,
  output logic g_o
);
  assign g_o = g_hi | (p_hi & g_lo);
endmodule

// File: rtl/pfx_ks_tree.sv
// Log-depth prefix network with a doubling stride per level.
// Level n holds spans of length 2^n.
// Positions below the stride pass through unchanged.
// Positions whose new span reaches bit 0 use gray cells; the rest use black cells.
// Group propagate is carried only for positions at or above 2^n,
// the only ones a later level reads.
module pfx_ks_tree #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] gen_i,
  input  logic [WIDTH-1:1] prop_i,
  output logic [WIDTH-1:0] gpre_o
);
  localparam int unsigned LVL = pfx_pkg::prefix_levels(WIDTH);

  for (genvar lv = 0; lv <= LVL; lv++) begin : st
    logic [WIDTH-1:0] gq;
    if (lv < LVL) begin : hp
      logic [WIDTH-1:(1 << lv)] pq;
    end

    if (lv == 0) begin : g_in
      assign gq       = gen_i;
      assign hp.pq    = prop_i;
    end else begin : g_lvl
      localparam int unsigned D = 1 << (lv - 1);
      for (genvar i = 0; i < WIDTH; i++) begin : bitpos
        if (i < D) begin : g_buf
          assign st[lv].gq[i] = st[lv-1].gq[i];
        end else if (i < 2 * D) begin : g_gry
          pfx_gray u_cell (
            .g_hi (st[lv-1].gq[i]),
            .p_hi (st[lv-1].hp.pq[i]),
            .g_lo (st[lv-1].gq[i-D]),
            .g_o  (st[lv].gq[i])
          );
        end else begin : g_blk
          pfx_black u_cell (
            .g_hi (st[lv-1].gq[i]),
            .p_hi (st[lv-1].hp.pq[i]),
            .g_lo (st[lv-1].gq[i-D]),
            .p_lo (st[lv-1].hp.pq[i-D]),
            .g_o  (st[lv].gq[i]),
            .p_o  (st[lv].hp.pq[i])
          );
        end
      end
    end
  end

  assign gpre_o = st[LVL].gq;
endmodule

// File: rtl/pfx_sum.sv
// Sum stage: each bit's propagate XOR the carry into it.
module pfx_sum #(
  parameter int unsigned WIDTH = 16
) (
  input  logic [WIDTH-1:0] prop_i,
  input  logic [WIDTH-1:0] gpre_i,
  input  logic             c0_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  assign sum_o  = prop_i ^ {gpre_i[WIDTH-2:0], c0_i};
  assign cout_o = gpre_i[WIDTH-1];
endmodule

// File: rtl/pfx_addsub.sv
module pfx_addsub #(
  parameter int unsigned WIDTH   = 16,
  parameter bit          OUT_REG = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             sub_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  if (!pfx_pkg::width_ok(WIDTH)) begin : g_bad_width
    $error("pfx_addsub: WIDTH must be a power of two >= 2");
  end

  logic [WIDTH-1:0] gen;
  logic [WIDTH-1:0] prop;
  logic             c0;
  logic [WIDTH-1:0] gpre;
  logic [WIDTH-1:0] sum_c;
  logic             cout_c;

  pfx_pg #(.WIDTH(WIDTH)) u_pg (
    .a_i    (a_i),
    .b_i    (b_i),
    .sub_i  (sub_i),
    .cin_i  (cin_i),
    .gen_o  (gen),
    .prop_o (prop),
    .c0_o   (c0)
  );

  pfx_ks_tree #(.WIDTH(WIDTH)) u_tree (
    .gen_i  (gen),
    .prop_i (prop[WIDTH-1:1]),
    .gpre_o (gpre)
  );

  pfx_sum #(.WIDTH(WIDTH)) u_sum (
    .prop_i (prop),
    .gpre_i (gpre),
    .c0_i   (c0),
    .sum_o  (sum_c),
    .cout_o (cout_c)
  );

  // Prefix result against the plain arithmetic of each mode.
  a_r1_add_result : assert property (@(posedge clk) disable iff (rst)
    !sub_i |-> ({cout_c, sum_c} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})));

  a_r2_sub_result : assert property (@(posedge clk) disable iff (rst)
    sub_i |-> (sum_c == (a_i - b_i)));

  a_r3_no_borrow : assert property (@(posedge clk) disable iff (rst)
    sub_i |-> (cout_c == (a_i >= b_i)));

  if (OUT_REG) begin : g_reg
    logic [WIDTH-1:0] sum_q;
    logic             cout_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        sum_q  <= '0;
        cout_q <= 1'b0;
      end else begin
        sum_q  <= sum_c;
        cout_q <= cout_c;
      end
    end

    assign sum_o  = sum_q;
    assign cout_o = cout_q;

    a_r5_one_cycle_add : assert property (@(posedge clk) disable iff (rst)
      !sub_i |=> ({cout_o, sum_o} ==
                  $past({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})));

    a_r6_reset_clears : assert property (@(posedge clk)
      rst |=> ((sum_o == '0) && !cout_o));
  end else begin : g_comb
    assign sum_o  = sum_c;
    assign cout_o = cout_c;
  end
endmodule

// File: tb/tb_pfx_addsub.sv
module tb_pfx_addsub;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] a = '0, b = '0;
  logic        sub = 1'b0, cin = 1'b0;
  logic [15:0] sum;
  logic        cout;

  logic [7:0]  a8 = '0, b8 = '0;
  logic        sub8 = 1'b0, cin8 = 1'b0;
  logic [7:0]  sum8;
  logic        cout8;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pfx_addsub #(.WIDTH(16), .OUT_REG(1'b1)) dut (
    .clk(clk), .rst(rst), .a_i(a), .b_i(b), .sub_i(sub), .cin_i(cin),
    .sum_o(sum), .cout_o(cout)
  );

  pfx_addsub #(.WIDTH(8), .OUT_REG(1'b0)) dut_w8 (
    .clk(clk), .rst(rst), .a_i(a8), .b_i(b8), .sub_i(sub8), .cin_i(cin8),
    .sum_o(sum8), .cout_o(cout8)
  );

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        sub;
    logic        cin;
    logic [15:0] s;
    logic        c;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0},
    '{16'hFFFF, 16'h0001, 1'b0, 1'b0, 16'h0000, 1'b1},
    '{16'hFFFF, 16'hFFFF, 1'b0, 1'b1, 16'hFFFF, 1'b1},
    '{16'hAAAA, 16'h5555, 1'b0, 1'b0, 16'hFFFF, 1'b0},
    '{16'hAAAA, 16'h5555, 1'b0, 1'b1, 16'h0000, 1'b1},
    '{16'h1234, 16'h1234, 1'b1, 1'b0, 16'h0000, 1'b1},
    '{16'h0000, 16'h0001, 1'b1, 1'b0, 16'hFFFF, 1'b0},
    '{16'h0000, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b1},
    '{16'h8000, 16'h0001, 1'b1, 1'b1, 16'h7FFF, 1'b1},
    '{16'h5555, 16'hAAAA, 1'b1, 1'b0, 16'hAAAB, 1'b0},
    '{16'h1234, 16'h4321, 1'b0, 1'b0, 16'h5555, 1'b0},
    '{16'h00FF, 16'h0001, 1'b0, 1'b0, 16'h0100, 1'b0},
    '{16'h7FFF, 16'h0001, 1'b0, 1'b0, 16'h8000, 1'b0},
    '{16'hFFFF, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b1},
    '{16'h0001, 16'hFFFF, 1'b1, 1'b0, 16'h0002, 1'b0},
    '{16'hFFFF, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b1}
  };

  task automatic check(input string req, input logic [15:0] got_s,
                       input logic [15:0] exp_s, input logic got_c,
                       input logic exp_c);
    checks++;
    if (got_s !== exp_s || got_c !== exp_c) begin
      errors++;
      $display("FAIL %s: sum=%h cout=%b expected sum=%h cout=%b",
               req, got_s, got_c, exp_s, exp_c);
    end
  endtask

  // Expected result from the stated arithmetic of each mode.
  function automatic logic [16:0] ref16(input logic [15:0] x, input logic [15:0] y,
                                        input logic s, input logic ci);
    if (s) return {1'b0, x} + {1'b0, ~y} + 17'd1;
    return {1'b0, x} + {1'b0, y} + {16'd0, ci};
  endfunction

  function automatic logic [8:0] ref8(input logic [7:0] x, input logic [7:0] y,
                                      input logic s, input logic ci);
    if (s) return {1'b0, x} + {1'b0, ~y} + 9'd1;
    return {1'b0, x} + {1'b0, y} + {8'd0, ci};
  endfunction

  // Drive on a falling edge; the register loads at the next rising edge,
  // so the result is sampled on the falling edge after that.
  task automatic apply16(input string req, input logic [15:0] x, input logic [15:0] y,
                         input logic s, input logic ci,
                         input logic [15:0] es, input logic ec);
    @(negedge clk);
    a = x; b = y; sub = s; cin = ci;
    @(negedge clk);
    check(req, sum, es, cout, ec);
  endtask

  task automatic apply8(input string req, input logic [7:0] x, input logic [7:0] y,
                        input logic s, input logic ci);
    logic [8:0] e;
    a8 = x; b8 = y; sub8 = s; cin8 = ci;
    #1;
    e = ref8(x, y, s, ci);
    check(req, {8'd0, sum8}, {8'd0, e[7:0]}, cout8, e[8]);
  endtask

  initial begin : watchdog
    #1_000_000;
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [16:0] e;
    // R6: reset state, and reset wins over nonzero operands.
    a = 16'hFFFF; b = 16'h0001; cin = 1'b1;
    repeat (3) @(negedge clk);
    check("R6 reset state", sum, 16'h0000, cout, 1'b0);
    @(negedge clk);
    check("R6 held while reset high", sum, 16'h0000, cout, 1'b0);
    rst = 1'b0;

    // Vector table: R1, R2, R3, R4.
    for (int k = 0; k < NV; k++) begin
      apply16(VECS[k].sub ? "R2 R3 vector" : "R1 R4 vector",
              VECS[k].a, VECS[k].b, VECS[k].sub, VECS[k].cin,
              VECS[k].s, VECS[k].c);
    end

    // R2: carry-in ignored in subtract mode.
    apply16("R2 cin ignored (cin=0)", 16'h4000, 16'h0FFF, 1'b1, 1'b0, 16'h3001, 1'b1);
    apply16("R2 cin ignored (cin=1)", 16'h4000, 16'h0FFF, 1'b1, 1'b1, 16'h3001, 1'b1);
    // R3: borrow boundary.
    apply16("R3 A one below B", 16'h7FFE, 16'h7FFF, 1'b1, 1'b0, 16'hFFFF, 1'b0);

    // R5: output holds until the next rising edge.
    apply16("R5 settle", 16'h0100, 16'h0200, 1'b0, 1'b0, 16'h0300, 1'b0);
    @(negedge clk);
    a = 16'h0001; b = 16'h0001;
    #1;
    check("R5 holds before edge", sum, 16'h0300, cout, 1'b0);
    @(negedge clk);
    check("R5 updates after one edge", sum, 16'h0002, cout, 1'b0);

    // Random operands in both modes (R1, R2, R3).
    for (int k = 0; k < 400; k++) begin
      logic [15:0] x, y;
      logic s, ci;
      x = 16'($urandom); y = 16'($urandom);
      s = 1'($urandom); ci = 1'($urandom);
      e = ref16(x, y, s, ci);
      apply16(s ? "R2 R3 random" : "R1 random", x, y, s, ci, e[15:0], e[16]);
    end

    // R6: synchronous clear mid-run.
    apply16("R6 before clear", 16'hF000, 16'h1000, 1'b0, 1'b0, 16'h0000, 1'b1);
    @(negedge clk);
    a = 16'h1111; b = 16'h2222; rst = 1'b1;
    @(negedge clk);
    check("R6 clear at edge", sum, 16'h0000, cout, 1'b0);
    rst = 1'b0;
    @(negedge clk);
    check("R6 resumes after clear", sum, 16'h3333, cout, 1'b0);

    // R7 with the 8-bit combinational instance; R5 same-cycle response.
    apply8("R7 R5 wrap", 8'hFF, 8'h01, 1'b0, 1'b0);
    apply8("R7 R4 carry chain", 8'hAA, 8'h55, 1'b0, 1'b1);
    apply8("R7 R3 borrow", 8'h00, 8'h01, 1'b1, 1'b0);
    apply8("R7 R3 equal", 8'h80, 8'h80, 1'b1, 1'b1);
    for (int k = 0; k < 500; k++) begin
      apply8("R7 random", 8'($urandom), 8'($urandom), 1'($urandom), 1'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule